// File: doc/BRIEF.md
# Configurable carry-save compressor tree

This block is a purely combinational reducer for multi-operand addition. It accepts N addend vectors of equal width W and returns M vectors of the same width, with M smaller than N. The M outputs always add up, modulo 2^W, to the same value as the N inputs. A later carry-propagate adder, which lies outside this block, merges the outputs into a single sum.

An elaboration parameter picks one of two implementations. The tree variant builds levels of full-adder cells in the Wallace style. Each level takes as many groups of three rows as it can and turns every group into a sum row and a carry row. Reduction stops once exactly M rows remain. When M is one, the last two rows are merged by a ripple chain that starts with a half adder. The adder variant writes the whole truncated sum to the last output and drives every other output to zero. Downstream tools can then choose their own compression for it.

The block has no clock and no reset. Input row k sits in `addends[k*W +: W]` and output row j sits in `rows_out[j*W +: W]`.

Top module: `cst_compress_tree`

## Requirements
- R1: In tree mode, the sum of the M output rows, modulo 2^W, equals the sum of the N input rows, modulo 2^W.
- R2: In adder mode, output row M-1 (`rows_out[(M-1)*W +: W]`) equals the sum of all input rows, truncated to W bits.
- R3: In adder mode, output rows 0 to M-2 are all zero for every input.
- R4: Carries beyond bit W-1 are dropped. With every input all ones, the outputs sum to (2^W - N) mod 2^W.
- R5: When every input row is zero, every output row is zero, in both modes.
- R6: In tree mode with M equal to 1, the single output row equals the input sum modulo 2^W.
- R7: The XOR of bit 0 over all output rows equals the XOR of bit 0 over all input rows.
- R8: Input row k is read from bits [k*W +: W]. A single nonzero row placed at any position k gives an output sum equal to that row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addends | input | N*W | N packed addend rows, row k at bits k*W upward |
| rows_out | output | M*W | M packed result rows, row j at bits j*W upward |

## Verification
A short table of arithmetic progressions drives the main configuration in both modes. Its rows start at zero, one, the sign bit and all ones, and some use nonzero steps. The all-ones and sign-bit rows show whether carries out of the top bit are dropped rather than folded back. The nonzero steps show whether every row position reaches the sum. Single nonzero rows at varying positions separate correct row packing from a shifted or dropped slot. Random rows on three tree configurations (M of 2, 3 and 1) exercise uneven level schedules, pass-through rows and the final ripple merge.

// File: rtl/cst_pkg.sv
package cst_pkg;

  typedef enum logic {
    CST_TREE  = 1'b0,
    CST_ADDER = 1'b1
  } cst_mode_e;

  // Number of 3:2 groups taken at a level holding `rows` rows when
  // the reduction must not go below `tgt` rows.
  function automatic int cst_groups(input int rows, input int tgt);
    int by3;
    int excess;
    by3    = rows / 3;
    excess = rows - tgt;
    if (excess < 0) excess = 0;
    return (by3 < excess) ? by3 : excess;
  endfunction

  // Row count present at level `lvl` (level 0 is the input).
  function automatic int cst_rows_at(input int n, input int m, input int lvl);
    int r;
    r = n;
    for (int l = 0; l < lvl; l++) r = r - cst_groups(r, m);
    return r;
  endfunction

  // Number of compression levels until no further 3:2 group applies.
  function automatic int cst_depth(input int n, input int m);
    int r;
    int d;
    r = n;
    d = 0;
    for (int l = 0; l < n; l++) begin
      if (cst_groups(r, m) > 0) begin
        r = r - cst_groups(r, m);
        d = d + 1;
      end
    end
    return d;
  endfunction

  function automatic logic cst_fa_sum(input logic a, input logic b, input logic c);
    return a ^ b ^ c;
  endfunction

  function automatic logic cst_fa_carry(input logic a, input logic b, input logic c);
    return (a & b) | (c & (a ^ b));
  endfunction

  function automatic logic cst_ha_sum(input logic a, input logic b);
    return a ^ b;
  endfunction

  function automatic logic cst_ha_carry(input logic a, input logic b);
    return a & b;
  endfunction

endpackage

// File: rtl/cst_fa_row.sv
// One word-wide 3:2 compressor: three rows in, a sum row and a
// left-shifted carry row out. The carry out of the top bit is dropped.
module cst_fa_row #(
  parameter int W = 16
) (
  input  logic [W-1:0] row_x,
  input  logic [W-1:0] row_y,
  input  logic [W-1:0] row_z,
  output logic [W-1:0] row_sum,
  output logic [W-1:0] row_cry
);
  import cst_pkg::*;

  assign row_cry[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign row_sum[i] = cst_fa_sum(row_x[i], row_y[i], row_z[i]);
    if (i < W - 1) begin : g_cry
      assign row_cry[i+1] = cst_fa_carry(row_x[i], row_y[i], row_z[i]);
    end
  end

endmodule

// File: rtl/cst_ripple_merge.sv
// Merges two rows into one: half adder at bit 0, full adders above,
// carry out of the top bit discarded. Needs W >= 2.
module cst_ripple_merge #(
  parameter int W = 16
) (
  input  logic [W-1:0] row_x,
  input  logic [W-1:0] row_y,
  output logic [W-1:0] row_sum
);
  import cst_pkg::*;

  logic [W-1:1] chain;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == 0) begin : g_half
      assign row_sum[0] = cst_ha_sum(row_x[0], row_y[0]);
      assign chain[1]   = cst_ha_carry(row_x[0], row_y[0]);
    end else begin : g_full
      assign row_sum[i] = cst_fa_sum(row_x[i], row_y[i], chain[i]);
      if (i < W - 1) begin : g_cry
        assign chain[i+1] = cst_fa_carry(row_x[i], row_y[i], chain[i]);
      end
    end
  end

endmodule

// File: rtl/cst_sum_all.sv
// Plain modulo-2^W sum of N packed rows.
module cst_sum_all #(
  parameter int N = 8,
  parameter int W = 16
) (
  input  logic [N*W-1:0] rows_in,
  output logic [W-1:0]   total
);

  always_comb begin
    total = '0;
    for (int k = 0; k < N; k++) total = total + rows_in[k*W +: W];
  end

endmodule

// File: rtl/cst_compress_tree.sv
module cst_compress_tree #(
  parameter int                 N    = 8,
  parameter int                 M    = 2,
  parameter int                 W    = 16,
  parameter cst_pkg::cst_mode_e MODE = cst_pkg::CST_TREE
) (
  input  logic [N*W-1:0] addends,
  output logic [M*W-1:0] rows_out
);
  import cst_pkg::*;

  localparam int DEPTH = cst_depth(N, M);
  localparam int FINAL = cst_rows_at(N, M, DEPTH);

  if (M < 1 || M >= N || W < 2) begin : g_bad_cfg
    $error("cst_compress_tree: need 1 <= M < N and W >= 2");
  end

  if (MODE == CST_ADDER) begin : g_adder
    logic [W-1:0] full_sum;

    cst_sum_all #(.N(N), .W(W)) u_sum (
      .rows_in (addends),
      .total   (full_sum)
    );

    assign rows_out[(M-1)*W +: W] = full_sum;
    if (M > 1) begin : g_zero
      assign rows_out[0 +: (M-1)*W] = '0;
    end
  end else begin : g_tree
    for (genvar l = 0; l <= DEPTH; l++) begin : g_lvl
      localparam int CR = cst_rows_at(N, M, l);
      logic [CR*W-1:0] rows;

      if (l == 0) begin : g_in
        assign rows = addends;
      end else begin : g_red
        localparam int PR = cst_rows_at(N, M, l - 1);
        localparam int K  = cst_groups(PR, M);

        for (genvar g = 0; g < K; g++) begin : g_csa
          cst_fa_row #(.W(W)) u_row (
            .row_x   (g_lvl[l-1].rows[(3*g)*W +: W]),
            .row_y   (g_lvl[l-1].rows[(3*g+1)*W +: W]),
            .row_z   (g_lvl[l-1].rows[(3*g+2)*W +: W]),
            .row_sum (rows[(2*g)*W +: W]),
            .row_cry (rows[(2*g+1)*W +: W])
          );
        end

        for (genvar p = 3*K; p < PR; p++) begin : g_pass
          assign rows[(2*K + p - 3*K)*W +: W] = g_lvl[l-1].rows[p*W +: W];
        end
      end
    end

    // Rows left after the last 3:2 level, named for inspection.
    logic [FINAL*W-1:0] tree_final;
    assign tree_final = g_lvl[DEPTH].rows;

    if (FINAL == M) begin : g_direct
      assign rows_out = tree_final;
    end else begin : g_merge
      cst_ripple_merge #(.W(W)) u_merge (
        .row_x   (tree_final[0 +: W]),
        .row_y   (tree_final[W +: W]),
        .row_sum (rows_out[0 +: W])
      );
    end
  end

endmodule

// File: rtl/cst_compress_tree_chk.sv
module cst_compress_tree_chk #(
  parameter int                 N    = 8,
  parameter int                 M    = 2,
  parameter int                 W    = 16,
  parameter cst_pkg::cst_mode_e MODE = cst_pkg::CST_TREE
) (
  input logic [N*W-1:0] addends,
  input logic [M*W-1:0] rows_out
);
  import cst_pkg::*;

  logic [W-1:0] in_total;
  logic [W-1:0] out_total;
  logic         in_par;
  logic         out_par;
  logic         in_zero;

  always_comb begin
    in_total  = '0;
    out_total = '0;
    in_par    = 1'b0;
    out_par   = 1'b0;
    for (int k = 0; k < N; k++) begin
      in_total = in_total + addends[k*W +: W];
      in_par   = in_par ^ addends[k*W];
    end
    for (int j = 0; j < M; j++) begin
      out_total = out_total + rows_out[j*W +: W];
      out_par   = out_par ^ rows_out[j*W];
    end
    in_zero = (addends == '0);
  end

  always_comb begin
    // R1, R4, R6: sums agree modulo 2^W
    p_sum_match_r1: assert (out_total == in_total);
    // R7: bit 0 parity preserved
    p_lsb_parity_r7: assert (out_par == in_par);
    // R5: zero in, zero out
    p_zero_in_r5: assert (!in_zero || rows_out == '0);
    // R2: adder mode last row carries the sum
    if (MODE == CST_ADDER) begin
      p_adder_last_r2: assert (rows_out[(M-1)*W +: W] == in_total);
    end
  end

endmodule

bind cst_compress_tree cst_compress_tree_chk #(
  .N(N), .M(M), .W(W), .MODE(MODE)
) u_chk (
  .addends  (addends),
  .rows_out (rows_out)
);

// File: tb/sim_cst_compress_tree.sv
module sim_cst_compress_tree;
  import cst_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;

  // u0/u1: N=8 M=2 W=16 (tree / adder); u2: N=5 M=1 W=8; u3: N=7 M=3 W=12
  logic [127:0] in_a = '0;
  logic [31:0]  out_t0;
  logic [31:0]  out_ad;
  logic [39:0]  in_c = '0;
  logic [7:0]   out_c;
  logic [83:0]  in_d = '0;
  logic [35:0]  out_d;

  cst_compress_tree #(.N(8), .M(2), .W(16), .MODE(CST_TREE)) u0 (
    .addends(in_a), .rows_out(out_t0));
  cst_compress_tree #(.N(8), .M(2), .W(16), .MODE(CST_ADDER)) u1 (
    .addends(in_a), .rows_out(out_ad));
  cst_compress_tree #(.N(5), .M(1), .W(8), .MODE(CST_TREE)) u2 (
    .addends(in_c), .rows_out(out_c));
  cst_compress_tree #(.N(7), .M(3), .W(12), .MODE(CST_TREE)) u3 (
    .addends(in_d), .rows_out(out_d));

  // {base, step, expected sum of 8 rows base + i*step, all mod 2^16}
  localparam logic [47:0] TABLE [8] = '{
    {16'h0000, 16'h0000, 16'h0000},
    {16'h0001, 16'h0000, 16'h0008},
    {16'hFFFF, 16'h0000, 16'hFFF8},
    {16'h0000, 16'h0001, 16'h001C},
    {16'h8000, 16'h0000, 16'h0000},
    {16'h1234, 16'h1111, 16'h6F7C},
    {16'hFFFF, 16'hFFFF, 16'hFFDC},
    {16'h00FF, 16'h0100, 16'h23F8}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] sum16(input logic [127:0] v, input int n);
    logic [15:0] s = '0;
    for (int i = 0; i < n; i++) s = s + v[i*16 +: 16];
    return s;
  endfunction

  function automatic logic [11:0] sum12(input logic [83:0] v, input int n);
    logic [11:0] s = '0;
    for (int i = 0; i < n; i++) s = s + v[i*12 +: 12];
    return s;
  endfunction

  function automatic logic [7:0] sum8(input logic [39:0] v, input int n);
    logic [7:0] s = '0;
    for (int i = 0; i < n; i++) s = s + v[i*8 +: 8];
    return s;
  endfunction

  function automatic logic par16(input logic [127:0] v, input int n);
    logic p = 1'b0;
    for (int i = 0; i < n; i++) p = p ^ v[i*16];
    return p;
  endfunction

  task automatic settle();
    #(CLK_PERIOD);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    // R5: all-zero inputs give all-zero outputs in every instance
    settle();
    check("R5 tree u0", {32'h0, out_t0}, 64'h0);
    check("R5 adder u1", {32'h0, out_ad}, 64'h0);
    check("R5 tree u2", {56'h0, out_c}, 64'h0);
    check("R5 tree u3", {28'h0, out_d}, 64'h0);

    // Table walk: R1 tree sum, R2 adder last row, R3 adder low row; R4 on wrap rows
    for (int t = 0; t < 8; t++) begin
      logic [15:0] b = TABLE[t][47:32];
      logic [15:0] d = TABLE[t][31:16];
      logic [15:0] e = TABLE[t][15:0];
      for (int i = 0; i < 8; i++) in_a[i*16 +: 16] = b + 16'(i) * d;
      settle();
      check("R1/R4 tree sum", {48'h0, sum16({96'h0, out_t0}, 2)}, {48'h0, e});
      check("R2/R4 adder last row", {48'h0, out_ad[31:16]}, {48'h0, e});
      check("R3 adder low row", {48'h0, out_ad[15:0]}, 64'h0);
    end

    // R4: all-ones on u2 (5 rows of 8 bits) -> 0xFB
    in_c = '1;
    in_d = '1;
    settle();
    check("R4/R6 u2 all ones", {56'h0, out_c}, 64'hFB);
    check("R4 u3 all ones", {52'h0, sum12({48'h0, out_d}, 3)}, 64'hFF9);

    // R8: single nonzero row at each position
    for (int k = 0; k < 8; k++) begin
      in_a = '0;
      in_a[k*16 +: 16] = 16'h00A5 + 16'(k);
      settle();
      check("R8 tree single row", {48'h0, sum16({96'h0, out_t0}, 2)}, {48'h0, 16'h00A5 + 16'(k)});
      check("R8 adder single row", {48'h0, out_ad[31:16]}, {48'h0, 16'h00A5 + 16'(k)});
    end

    // Random rows: R1, R2, R3, R6, R7
    for (int r = 0; r < 200; r++) begin
      for (int i = 0; i < 4; i++) in_a[i*32 +: 32] = $urandom;
      in_c = {8'($urandom), $urandom};
      in_d = {20'($urandom), $urandom, $urandom};
      settle();
      check("R1 tree random", {48'h0, sum16({96'h0, out_t0}, 2)}, {48'h0, sum16(in_a, 8)});
      check("R2 adder random", {48'h0, out_ad[31:16]}, {48'h0, sum16(in_a, 8)});
      check("R3 adder random", {48'h0, out_ad[15:0]}, 64'h0);
      check("R6 single output", {56'h0, out_c}, {56'h0, sum8(in_c, 5)});
      check("R1 tree M3 random", {52'h0, sum12({48'h0, out_d}, 3)}, {52'h0, sum12(in_d, 7)});
      check("R7 lsb parity", {63'h0, par16({96'h0, out_t0}, 2)}, {63'h0, par16(in_a, 8)});
    end

    // R5 again after activity
    in_a = '0;
    in_c = '0;
    in_d = '0;
    settle();
    check("R5 tree u0 after", {32'h0, out_t0}, 64'h0);
    check("R5 tree u2 after", {56'h0, out_c}, 64'h0);

    finish_run();
  end

endmodule